// File: doc/BRIEF.md
# Clock-Pair Enable Register Slave on a Two-Wire Bus

This block is the control side of a ten-pair differential clock fan-out buffer. A host on a two-wire serial bus reaches it at a fixed 7-bit address, 0x6A. The write address byte is 0xD4 and the read address byte is 0xD5. Through this address the host reads and writes a small bank of seven byte registers. Two of these registers hold one enable bit per output pair. The block drives the ten enable bits as a vector, and the fan-out logic outside it uses that vector to gate each pair.

Both serial lines pass through a synchronizer into the system clock domain. The data line is driven only low, through a drive enable, and the board pull-up releases it. The block supports two kinds of access. An SMBus-style block mode is selected by command code 0x00, and a single-byte access is selected by any other command code. In both kinds the register pointer advances by one after each data byte.

Top module: `clkbuf_en_slave`

## Requirements
- R1: After reset all ten pair enables are 1 (every pair active) and the data line is not driven.
- R2: Only the address byte 0xD4 (write) or 0xD5 (read) is acknowledged. After any other address byte, the block leaves SDA released for the rest of the transfer, and register contents do not change.
- R3: Single-byte write: address 0xD4, then a nonzero command N, then a data byte. The data byte goes to register N, and the block acknowledges the address, the command and the data byte.
- R4: Register 5 maps bits to pairs as follows: bit7 to pair 0, bit6 to pair 1, bit5 to pair 2, bit4 to pair 3, bit3 to pair 4, bit2 to pair 9. A 1 enables the pair and a 0 disables it.
- R5: Register 6 maps bits to pairs as follows: bit4 to pair 8, bit3 to pair 7, bit2 to pair 6, bit1 to pair 5. A write to register 6 leaves pairs 0 to 4 and pair 9 unchanged.
- R6: Writes to registers 0 to 4, to any register above 6 and to reserved bits change no enable. A read of any of these locations returns 1 in every reserved position. Registers 0 to 4 and any index above 6 read 0xFF, and bits 1 and 0 of register 5 and bits 7, 6, 5 and 0 of register 6 read 1.
- R7: Single-byte read: a write of the command N, then a repeated START, then address 0xD5. The block returns the current value of register N. After the master NACKs a read byte, the block releases SDA and waits for the next START.
- R8: Block write with command 0x00: the next byte is a count and is not stored. The data bytes that follow fill registers 0, 1, 2 and onward in ascending order.
- R9: Block read after command 0x00 and a repeated START: the first byte returned is the count 7, followed by registers 0 to 6 in ascending order.
- R10: Except at a START or STOP condition, the data-line drive enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| pair_en | output | 10 | Enable per clock pair, bit k for pair k, 1 means active |

## Verification
The assertions check the following on every cycle:
- the drive enable moves only while SCL is low;
- the data line is never driven while the engine is idle;
- a master NACK releases the line;
- a write to a reserved register or to register 6 leaves the other enables unchanged.

The scattered bit-to-pair mapping can only be shown by the bench's scenarios, which drive real bus transfers. The same holds for the count byte being skipped in a block write, the count-first order of a block read, and the pointer carrying across a repeated START.

// File: rtl/clkbuf_ctl_pkg.sv
package clkbuf_ctl_pkg;

    localparam int NUM_PAIRS = 10;
    localparam int NUM_REGS  = 7;
    localparam int REG_W     = 8;
    localparam logic [REG_W-1:0] CTL_A = 8'd5;
    localparam logic [REG_W-1:0] CTL_B = 8'd6;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_RACK, ST_TX, ST_TACK, ST_TNEXT
    } slv_state_t;

    typedef enum logic [1:0] {
        K_ADDR, K_CMD, K_CNT, K_DATA
    } rx_kind_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic             en;
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] data;
    } reg_wr_t;

    typedef struct packed {
        logic [REG_W-1:0] ra;
        logic [2:0]       bp;
    } pair_loc_t;

    // Register index and bit position that hold the enable of pair p.
    function automatic pair_loc_t pair_loc(input int p);
        pair_loc_t l;
        if (p <= 4) begin
            l.ra = CTL_A;
            l.bp = 3'(7 - p);
        end else if (p == 9) begin
            l.ra = CTL_A;
            l.bp = 3'd2;
        end else begin
            l.ra = CTL_B;
            l.bp = 3'(p - 4);
        end
        return l;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import clkbuf_ctl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] scl_pipe, sda_pipe;
    logic          scl_prev, sda_prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
                    sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_pipe[LAST];
            sda_prev <= sda_pipe[LAST];
        end
    end

    always_comb begin
        ev.scl      = scl_pipe[LAST];
        ev.sda      = sda_pipe[LAST];
        ev.scl_rise = scl_pipe[LAST] & ~scl_prev;
        ev.scl_fall = ~scl_pipe[LAST] & scl_prev;
        ev.start    = scl_pipe[LAST] & scl_prev & sda_prev & ~sda_pipe[LAST];
        ev.stop     = scl_pipe[LAST] & scl_prev & ~sda_prev & sda_pipe[LAST];
    end

endmodule

// File: rtl/i2c_ctl_fsm.sv
module i2c_ctl_fsm
    import clkbuf_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6A
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] rd_addr,
    output reg_wr_t          wr,
    output logic             sda_oe
);
    slv_state_t       st;
    rx_kind_t         kind;
    logic [3:0]       cnt;
    logic [REG_W-1:0] sh, tx, ptr, ld_byte;
    logic             blk, cnt_sent, rd_mode;

    assign rd_addr = ptr;

    always_comb begin
        ld_byte = (blk && !cnt_sent) ? REG_W'(NUM_REGS) : rd_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            kind     <= K_ADDR;
            cnt      <= '0;
            sh       <= '0;
            tx       <= '0;
            ptr      <= '0;
            blk      <= 1'b0;
            cnt_sent <= 1'b0;
            rd_mode  <= 1'b0;
            sda_oe   <= 1'b0;
            wr       <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                st       <= ST_RX;
                kind     <= K_ADDR;
                cnt      <= '0;
                cnt_sent <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (ev.scl_rise) begin
                            sh  <= {sh[REG_W-2:0], ev.sda};
                            cnt <= cnt + 4'd1;
                        end else if (ev.scl_fall && cnt == 4'd8) begin
                            cnt    <= '0;
                            st     <= ST_RACK;
                            sda_oe <= 1'b1;
                            case (kind)
                                K_ADDR: begin
                                    if (sh[7:1] != DEV_ADDR) begin
                                        st     <= ST_IDLE;
                                        sda_oe <= 1'b0;
                                    end else begin
                                        rd_mode <= sh[0];
                                        kind    <= K_CMD;
                                    end
                                end
                                K_CMD: begin
                                    ptr  <= sh;
                                    blk  <= (sh == '0);
                                    kind <= (sh == '0) ? K_CNT : K_DATA;
                                end
                                K_CNT: kind <= K_DATA;
                                default: begin
                                    wr.en   <= 1'b1;
                                    wr.addr <= ptr;
                                    wr.data <= sh;
                                    ptr     <= ptr + 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_fall) begin
                            if (rd_mode) begin
                                tx     <= ld_byte;
                                sda_oe <= ~ld_byte[7];
                                cnt    <= '0;
                                st     <= ST_TX;
                                if (blk && !cnt_sent) cnt_sent <= 1'b1;
                                else                  ptr      <= ptr + 1'b1;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (ev.scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                st     <= ST_TACK;
                            end else begin
                                sda_oe <= ~tx[6];
                                tx     <= {tx[REG_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_TACK: begin
                        if (ev.scl_rise) st <= ev.sda ? ST_IDLE : ST_TNEXT;
                    end
                    ST_TNEXT: begin
                        if (ev.scl_fall) begin
                            tx     <= ld_byte;
                            sda_oe <= ~ld_byte[7];
                            cnt    <= '0;
                            st     <= ST_TX;
                            if (blk && !cnt_sent) cnt_sent <= 1'b1;
                            else                  ptr      <= ptr + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: line drive moves only while SCL is low, bus conditions aside
    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) && !$past(ev.start || ev.stop) |-> !ev.scl);

    // R2: nothing driven while idle (also after a foreign address)
    a_r2_idle_released: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe);

    // R7: master NACK releases the line and ends the read
    a_r7_nack_release: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TACK && ev.scl_rise && ev.sda && !ev.start && !ev.stop)
        |=> (!sda_oe && st == ST_IDLE));

endmodule

// File: rtl/pair_en_regs.sv
module pair_en_regs
    import clkbuf_ctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  reg_wr_t              wr,
    input  logic [REG_W-1:0]     rd_addr,
    output logic [REG_W-1:0]     rd_data,
    output logic [NUM_PAIRS-1:0] pair_en
);
    generate
        for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
            localparam pair_loc_t LOC = pair_loc(p);
            always_ff @(posedge clk) begin
                if (rst)
                    pair_en[p] <= 1'b1;
                else if (wr.en && wr.addr == LOC.ra)
                    pair_en[p] <= wr.data[LOC.bp];
            end
        end
    endgenerate

    always_comb begin
        pair_loc_t l;
        rd_data = '1;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            l = pair_loc(p);
            if (l.ra == rd_addr) rd_data[l.bp] = pair_en[p];
        end
    end

    // R1: reset leaves every pair active
    a_r1_reset_all_on: assert property (@(posedge clk)
        $past(rst) |-> (&pair_en));

    // R6: reserved registers leave all enables untouched
    a_r6_reserved_no_effect: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr != CTL_A && wr.addr != CTL_B) |=> (pair_en == $past(pair_en)));

    // R5: a register-6 write keeps the register-5 pairs
    a_r5_keeps_other_pairs: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == CTL_B) |=> ({pair_en[9], pair_en[4:0]} == $past({pair_en[9], pair_en[4:0]})));

endmodule

// File: rtl/clkbuf_en_slave.sv
module clkbuf_en_slave
    import clkbuf_ctl_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h6A
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe,
    output logic [NUM_PAIRS-1:0] pair_en
);
    bus_ev_t          ev;
    reg_wr_t          wr;
    logic [REG_W-1:0] rd_addr, rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    i2c_ctl_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst(rst), .ev(ev), .rd_data(rd_data),
        .rd_addr(rd_addr), .wr(wr), .sda_oe(sda_oe)
    );

    pair_en_regs u_regs (
        .clk(clk), .rst(rst), .wr(wr), .rd_addr(rd_addr),
        .rd_data(rd_data), .pair_en(pair_en)
    );

endmodule

// File: tb/sim_clkbuf_en_slave.sv
module sim_clkbuf_en_slave;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_oe;
    logic [9:0] pair_en;
    logic       sda_line;
    logic [9:0] mdl;
    int         n_vec = 0, n_bad = 0, viol = 0;
    logic       done = 1'b0;
    logic       prev_oe = 1'b0;

    assign sda_line = !(m_low || sda_oe);

    always #2.5 clk = ~clk;

    clkbuf_en_slave u0 (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .pair_en(pair_en)
    );

    // R10 monitor: drive enable must not move while the bench holds SCL high
    always @(negedge clk) begin
        if (!rst && sda_oe !== prev_oe && scl) viol++;
        prev_oe = sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected register view per R4/R5/R6
    function automatic logic [7:0] view(input logic [7:0] a);
        case (a)
            8'd5:    return {mdl[0], mdl[1], mdl[2], mdl[3], mdl[4], mdl[9], 2'b11};
            8'd6:    return {3'b111, mdl[8], mdl[7], mdl[6], mdl[5], 1'b1};
            default: return 8'hFF;
        endcase
    endfunction

    task automatic apply(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'd5) begin
            mdl[0] = d[7]; mdl[1] = d[6]; mdl[2] = d[5];
            mdl[3] = d[4]; mdl[4] = d[3]; mdl[9] = d[2];
        end else if (a == 8'd6) begin
            mdl[8] = d[4]; mdl[7] = d[3]; mdl[6] = d[2]; mdl[5] = d[1];
        end
    endtask

    task automatic q();
        repeat (10) @(negedge clk);
    endtask

    task automatic bit_w(input logic b);
        m_low = !b; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    endtask

    task automatic bit_r(output logic b);
        m_low = 1'b0; q(); scl = 1'b1; q(); b = sda_line; q(); scl = 1'b0; q();
    endtask

    task automatic bus_start();
        m_low = 1'b0; q(); scl = 1'b1; q(); m_low = 1'b1; q(); scl = 1'b0; q();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; q(); scl = 1'b1; q(); m_low = 1'b0; q();
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_w(d[i]);
        bit_r(b);
        ack = !b;
    endtask

    task automatic rbyte(input logic last, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) bit_r(d[i]);
        bit_w(last);
    endtask

    task automatic t_reset();
        chk("R1 enables", 32'(pair_en), 32'h3FF);
        chk("R1 sda", 32'(sda_oe), 32'd0);
    endtask

    task automatic t_bad_addr(input logic [7:0] ab);
        logic a0, a1, a2;
        bus_start();
        wbyte(ab, a0); wbyte(8'h05, a1); wbyte(8'h00, a2);
        bus_stop();
        chk("R2 nack", {29'd0, a0, a1, a2}, 32'd0);
        chk("R2 no change", 32'(pair_en), 32'(mdl));
    endtask

    task automatic t_byte_write(input string req, input logic [7:0] ra, input logic [7:0] d);
        logic a0, a1, a2;
        bus_start();
        wbyte(8'hD4, a0); wbyte(ra, a1); wbyte(d, a2);
        bus_stop();
        apply(ra, d);
        chk("R3 acks", {29'd0, a0, a1, a2}, 32'h7);
        chk(req, 32'(pair_en), 32'(mdl));
    endtask

    task automatic t_byte_read(input string req, input logic [7:0] ra);
        logic a0, a1, a2;
        logic [7:0] d;
        bus_start();
        wbyte(8'hD4, a0); wbyte(ra, a1);
        bus_start();
        wbyte(8'hD5, a2);
        rbyte(1'b1, d);
        chk("R7 released", 32'(sda_oe), 32'd0);
        bus_stop();
        chk("R7 acks", {29'd0, a0, a1, a2}, 32'h7);
        chk(req, 32'(d), 32'(view(ra)));
    endtask

    task automatic t_block_write();
        logic [7:0] dat [7] = '{8'h00, 8'h11, 8'h22, 8'h33, 8'h00, 8'h83, 8'h14};
        logic ack;
        int nack = 0;
        bus_start();
        wbyte(8'hD4, ack); if (!ack) nack++;
        wbyte(8'h00, ack); if (!ack) nack++;
        wbyte(8'h07, ack); if (!ack) nack++;
        for (int i = 0; i < 7; i++) begin
            wbyte(dat[i], ack); if (!ack) nack++;
            apply(8'(i), dat[i]);
        end
        bus_stop();
        chk("R8 acks", 32'(nack), 32'd0);
        chk("R8 block data", 32'(pair_en), 32'(mdl));
    endtask

    task automatic t_block_read();
        logic a0, a1, a2;
        logic [7:0] d;
        bus_start();
        wbyte(8'hD4, a0); wbyte(8'h00, a1);
        bus_start();
        wbyte(8'hD5, a2);
        chk("R9 acks", {29'd0, a0, a1, a2}, 32'h7);
        rbyte(1'b0, d);
        chk("R9 count", 32'(d), 32'd7);
        for (int i = 0; i < 7; i++) begin
            rbyte(i == 6, d);
            chk("R9 reg", 32'(d), 32'(view(8'(i))));
        end
        chk("R7 released after nack", 32'(sda_oe), 32'd0);
        bus_stop();
    endtask

    initial begin
        mdl = 10'h3FF;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        q();
        t_reset();
        t_bad_addr(8'hA0);
        t_bad_addr(8'hD6);
        t_byte_write("R4 reg5", 8'd5, 8'h55);
        t_byte_write("R5 reg6", 8'd6, 8'h0A);
        t_byte_write("R6 reserved reg", 8'd2, 8'h00);
        t_byte_write("R6 reserved bits", 8'd6, 8'hE1 | 8'h0A);
        t_byte_read("R7 reg5", 8'd5);
        t_byte_read("R7 reg6", 8'd6);
        t_byte_read("R6 read reg2", 8'd2);
        t_byte_read("R6 read reg9", 8'd9);
        t_block_write();
        t_block_read();
        t_byte_read("R7 reg5 after block", 8'd5);
        chk("R10 sda moved with scl high", 32'(viol), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule